// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host and an external 128K x 8 asynchronous static RAM. The host issues single-beat reads and writes over a valid/ready handshake. The block then produces the RAM's control waveforms. These are a pair of chip selects of opposite polarity, an output enable and a write enable, together with a registered address and a shared 8-bit data bus that the block drives through a separate enable. Every timing interval is a whole number of clock cycles, set by parameters derived from the clock period: the read access window, the write pulse width, the full write cycle and the bus turnaround after a read.

A read holds the RAM selected with its outputs enabled for the whole access window. The block samples the data bus on the last cycle of that window and returns the byte with a one-cycle valid pulse. A write goes through three phases: a setup cycle, a write-enable pulse during which the block drives the data bus, and a recovery phase. When a write comes soon after a read, the block holds the write back long enough for the RAM to release the bus. A sleep input parks the RAM in its data-retention standby state, with both chip selects inactive, and keeps new requests out until sleep is released.

Top module: `sram_ctl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_cs is 1, mem_dq_oe is 0 and rd_valid is 0. With sleep low, req_ready is 1 once reset is released.
- R2: req_ready is 1 only while the controller is idle and sleep is low. A request is taken on a clock edge where req_valid and req_ready are both 1, and req_ready is 0 in the cycle after that edge.
- R3: For a read, each of the READ_CYC cycles after the accepting edge shows mem_cs_n=0, mem_cs=1, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0, with mem_addr equal to the requested address.
- R4: mem_dq_in is sampled at the end of the last of those READ_CYC cycles. In the cycle that follows, rd_valid is 1 for that one cycle only, rd_data equals the sample, and mem_cs_n and mem_oe_n are 1.
- R5: For a write, the first non-turnaround cycle after acceptance is a setup cycle (mem_cs_n=0, mem_cs=1, mem_we_n=1). mem_we_n is then 0 for exactly WE_PULSE_CYC cycles, followed by max(1, WR_CYC-1-WE_PULSE_CYC) recovery cycles that stay selected with mem_we_n=1. mem_oe_n is 1 and mem_addr holds the request address throughout.
- R6: mem_dq_oe is 1 exactly in the cycles where mem_we_n is 0, and in those cycles mem_dq_out equals the request's write data.
- R7: Count the cycle in which mem_oe_n rises as cycle 0. mem_dq_oe never rises before cycle TURN_CYC. A write accepted at the end of cycle a spends max(0, TURN_CYC-a-2) turnaround cycles with idle pins before its setup cycle; a write accepted later adds no extra cycle.
- R8: When sleep is 1 and the controller is idle, req_ready is 0 at once. From the next cycle, mem_cs_n=1, mem_cs=0, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0 until sleep falls, and no request is accepted. A transfer already in progress runs to completion before standby begins, and stored data is read back unchanged afterwards.
- R9: In idle cycles between transfers, with sleep low, the pins {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe} read 1,1,1,1,0.
- R10: rd_data keeps the last read result through later writes until another read completes.
- R11: mem_dq_oe is never 1 in a cycle where the RAM drives the bus, that is, with mem_cs_n=0, mem_cs=1, mem_oe_n=0 and mem_we_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Request data-retention standby |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data is new |
| rd_data | output | 8 | Last read result |
| mem_addr | output | 17 | RAM address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the bus drivers |
| mem_dq_in | input | 8 | Data seen on the RAM bus |

## Verification
A wrong state in the sequencer shows up at the pins within one cycle: a miscounted read window moves the rd_valid pulse or captures a placeholder byte that the RAM model presents until its access time has passed, and a miscounted write pulse changes the number of low cycles on mem_we_n. A turnaround decision made too early raises mem_dq_oe while the model may still be driving. The bench catches this through its gap monitor, through a conflict counter and through the per-cycle pin checks in each write. A standby fault appears as a selected chip or a raised req_ready in the cycle after sleep goes high.

// File: rtl/sram_ctl_pkg.sv
// Shared types for the asynchronous SRAM controller.
// Assumes a single clock domain; all cycle counts are set by the top.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_RD_WAIT,
        ST_RD_DONE,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic cs;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } mem_ctl_t;

    // Control pin pattern for each state; used for the registered outputs.
    function automatic mem_ctl_t ctl_of(ctl_state_e s);
        mem_ctl_t c;
        c = '{cs_n: 1'b1, cs: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        case (s)
            ST_SLEEP:    c.cs = 1'b0;
            ST_RD_WAIT:  begin c.cs_n = 1'b0; c.oe_n = 1'b0; end
            ST_WR_SETUP: c.cs_n = 1'b0;
            ST_WR_PULSE: begin c.cs_n = 1'b0; c.we_n = 1'b0; c.dq_oe = 1'b1; end
            ST_WR_RECOV: c.cs_n = 1'b0;
            default:     c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Down-counter that times one phase of a transfer.
// Loaded with (cycles - 1) on entry to a phase; done is high in the phase's last cycle.
module sram_ctl_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    // Load on phase entry, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_turn.sv
// Tracks how long the RAM outputs have been disabled after a read.
// Assumes TURN_CYC >= 1. turn_ok says that a write accepted now may go straight to setup.
module sram_ctl_turn #(
    parameter int TURN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_low,
    output logic turn_ok
);
    localparam int RW = $clog2(TURN_CYC + 1);

    logic [RW-1:0] rel_q;

    // Cycles since output enable was released, saturating at TURN_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rel_q <= RW'(TURN_CYC);
        else if (oe_low)
            rel_q <= '0;
        else if (int'(rel_q) < TURN_CYC)
            rel_q <= rel_q + 1'b1;
    end

    // The write pulse starts two cycles after acceptance (setup, then pulse).
    assign turn_ok = (int'(rel_q) + 2) >= TURN_CYC;
endmodule

// File: rtl/sram_ctl_fsm.sv
// Transfer sequencer: handshake, read window, write phases, turnaround and standby.
// Control pins are registered from the next state so that they change cleanly on edges.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int READ_CYC     = 7,
    parameter int WE_PULSE_CYC = 5,
    parameter int REC_CYC      = 1,
    parameter int TW           = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          tmr_done,
    input  logic          turn_ok,
    output logic          req_ready,
    output logic          accept,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          rd_capture,
    output logic          rd_valid,
    output mem_ctl_t      ctl
);
    ctl_state_e state_q, state_d;

    assign req_ready  = (state_q == ST_IDLE) && !sleep;
    assign accept     = req_ready && req_valid;
    assign rd_capture = (state_q == ST_RD_WAIT) && tmr_done;

    // Next-state and phase-timer load decisions.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (sleep) begin
                    state_d = ST_SLEEP;
                end else if (req_valid) begin
                    if (req_write) begin
                        state_d = turn_ok ? ST_WR_SETUP : ST_TURN;
                    end else begin
                        state_d  = ST_RD_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(READ_CYC - 1);
                    end
                end
            end
            ST_SLEEP:   if (!sleep) state_d = ST_IDLE;
            ST_RD_WAIT: if (tmr_done) state_d = ST_RD_DONE;
            ST_RD_DONE: state_d = ST_IDLE;
            ST_TURN:    if (turn_ok) state_d = ST_WR_SETUP;
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = TW'(WE_PULSE_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    state_d  = ST_WR_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(REC_CYC - 1);
                end
            end
            ST_WR_RECOV: if (tmr_done) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register plus registered control pins and read-valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ctl      <= ctl_of(ST_IDLE);
            rd_valid <= 1'b0;
        end else begin
            state_q  <= state_d;
            ctl      <= ctl_of(state_d);
            rd_valid <= (state_d == ST_RD_DONE);
        end
    end
endmodule

// File: rtl/sram_ctl_dp.sv
// Address, write-data and read-data registers of the controller.
// Address and write data are held from acceptance until the next request.
module sram_ctl_dp #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          rd_capture,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic [DW-1:0] rd_data
);
    // Latch request fields when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Sample the RAM bus on the last cycle of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_capture)
            rd_data <= mem_dq_in;
    end
endmodule

// File: rtl/sram_ctl.sv
// Top of the asynchronous SRAM controller.
// Assumes READ_CYC, WE_PULSE_CYC, WR_CYC and TURN_CYC are at least 1 and already
// rounded up from the RAM's nanosecond limits for the chosen clock period.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW           = 17,
    parameter int DW           = 8,
    parameter int READ_CYC     = 7,
    parameter int WE_PULSE_CYC = 5,
    parameter int WR_CYC       = 7,
    parameter int TURN_CYC     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int REC_RAW = WR_CYC - 1 - WE_PULSE_CYC;
    localparam int REC_CYC = (REC_RAW < 1) ? 1 : REC_RAW;
    localparam int TMAX_A  = (READ_CYC > WE_PULSE_CYC) ? READ_CYC : WE_PULSE_CYC;
    localparam int TMAX    = (TMAX_A > REC_CYC) ? TMAX_A : REC_CYC;
    localparam int TW      = $clog2(TMAX + 1);

    logic          accept, tmr_load, tmr_done, turn_ok, rd_capture;
    logic [TW-1:0] tmr_val;
    mem_ctl_t      ctl;

    sram_ctl_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctl_turn #(.TURN_CYC(TURN_CYC)) u_turn (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_low  (!ctl.oe_n),
        .turn_ok (turn_ok)
    );

    sram_ctl_fsm #(
        .READ_CYC     (READ_CYC),
        .WE_PULSE_CYC (WE_PULSE_CYC),
        .REC_CYC      (REC_CYC),
        .TW           (TW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .tmr_done   (tmr_done),
        .turn_ok    (turn_ok),
        .req_ready  (req_ready),
        .accept     (accept),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .rd_capture (rd_capture),
        .rd_valid   (rd_valid),
        .ctl        (ctl)
    );

    sram_ctl_dp #(.AW(AW), .DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_capture (rd_capture),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_data    (rd_data)
    );

    assign mem_cs_n  = ctl.cs_n;
    assign mem_cs    = ctl.cs;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_dq_oe = ctl.dq_oe;
endmodule

// File: rtl/sram_ctl_chk.sv
// Protocol checker for the SRAM controller pins, bound into every sram_ctl instance.
// Uses small counters for the pulse-width and turnaround windows.
module sram_ctl_chk #(
    parameter int WE_PULSE_CYC = 5,
    parameter int TURN_CYC     = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sleep,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic mem_cs_n,
    input logic mem_cs,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe
);
    localparam int WW = $clog2(WE_PULSE_CYC + 2);
    localparam int GW = $clog2(TURN_CYC + 1);

    logic [WW-1:0] we_lo_cnt;
    logic [GW-1:0] oe_gap;

    // Length of the current write-enable low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            we_lo_cnt <= '0;
        else if (!mem_we_n && int'(we_lo_cnt) <= WE_PULSE_CYC)
            we_lo_cnt <= we_lo_cnt + 1'b1;
        else if (mem_we_n)
            we_lo_cnt <= '0;
    end

    // Cycles since output enable was released, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe_gap <= GW'(TURN_CYC);
        else if (!mem_oe_n)
            oe_gap <= '0;
        else if (int'(oe_gap) < TURN_CYC)
            oe_gap <= oe_gap + 1'b1;
    end

    // R6
    dq_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe == !mem_we_n);

    // R5
    we_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n));

    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_lo_cnt) == WE_PULSE_CYC));

    // R5
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n));

    // R3
    oe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_cs && mem_we_n));

    // R7
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(oe_gap) >= TURN_CYC));

    // R4
    rd_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8
    standby_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R8
    standby_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !req_ready);

    // R2
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_ctl sram_ctl_chk #(
    .WE_PULSE_CYC (WE_PULSE_CYC),
    .TURN_CYC     (TURN_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
// Directed bench for sram_ctl with a behavioural RAM model on the shared bus.
module sram_ctl_tb;
    localparam int READ_CYC = 7;
    localparam int WE_CYC   = 5;
    localparam int WR_CYC   = 7;
    localparam int TURN_CYC = 4;
    localparam int REC_CYC  = ((WR_CYC - 1 - WE_CYC) < 1) ? 1 : (WR_CYC - 1 - WE_CYC);

    localparam logic [4:0] P_IDLE  = 5'b11110;
    localparam logic [4:0] P_SLEEP = 5'b10110;
    localparam logic [4:0] P_READ  = 5'b01010;
    localparam logic [4:0] P_SEL   = 5'b01110;
    localparam logic [4:0] P_PULSE = 5'b01101;

    logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rd_valid, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  rd_data, mem_dq_out, dq_in, model_val;
    logic [16:0] mem_addr;
    int n_chk = 0, n_bad = 0, n_conflict = 0, n_turn_bad = 0, n_turn_seen = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sram_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_in)
    );

    wire [4:0] pins = {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe};
    wire model_drv = !mem_cs_n && mem_cs && !mem_oe_n && mem_we_n;
    assign dq_in = mem_dq_oe ? mem_dq_out : (model_drv ? model_val : 8'h00);

    // RAM model: stores during the write pulse, shows a placeholder byte until the
    // access window has elapsed, counts bus conflicts and monitors the turnaround gap.
    logic [7:0] model_mem [logic [16:0]];
    int age = 0, gap = 100;
    logic [16:0] last_addr = '0;
    logic prev_dq = 1'b0;
    initial model_val = 8'hEE;
    always @(negedge clk) begin
        if (mem_dq_oe && model_drv) n_conflict++;
        if (!mem_cs_n && mem_cs && !mem_we_n) model_mem[mem_addr] = dq_in;
        if (model_drv) age = (age != 0 && mem_addr == last_addr) ? age + 1 : 1;
        else age = 0;
        last_addr = mem_addr;
        if (age >= READ_CYC)
            model_val = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'h00;
        else
            model_val = 8'hEE;
        if (!mem_oe_n) gap = 0; else if (gap < 100) gap++;
        if (mem_dq_oe && !prev_dq) begin
            n_turn_seen++;
            if (gap < TURN_CYC + 1) n_turn_bad++;
        end
        prev_dq = mem_dq_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int turn_extra(input int a);
        return (TURN_CYC - a - 2 > 0) ? TURN_CYC - a - 2 : 0;
    endfunction

    // Present a request and return just after the edge that accepts it.
    task automatic issue(input logic wr, input logic [16:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk("R2 ready drops after accept", {31'b0, req_ready}, 32'd0);
    endtask

    // Read and check pins per cycle; ends at the negedge of the rd_valid cycle.
    task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
        issue(1'b0, a, 8'h00);
        for (int i = 0; i < READ_CYC; i++) begin
            @(negedge clk);
            chk("R3 read pins", {27'b0, pins}, {27'b0, P_READ});
            chk("R3 read address", {15'b0, mem_addr}, {15'b0, a});
        end
        @(negedge clk);
        chk("R4 rd_valid pulse", {31'b0, rd_valid}, 32'd1);
        chk("R4 read data", {24'b0, rd_data}, {24'b0, exp});
        chk("R4 deselect after read", {30'b0, mem_cs_n, mem_oe_n}, 32'd3);
    endtask

    task automatic rd_tail();
        @(negedge clk);
        chk("R4 rd_valid single cycle", {31'b0, rd_valid}, 32'd0);
        chk("R9 idle pins after read", {27'b0, pins}, {27'b0, P_IDLE});
    endtask

    // Write with 'extra' expected turnaround cycles; ends at the negedge of the idle cycle.
    task automatic do_write(input logic [16:0] a, input logic [7:0] d, input int extra);
        issue(1'b1, a, d);
        for (int i = 0; i < extra; i++) begin
            @(negedge clk);
            chk("R7 turnaround pins", {27'b0, pins}, {27'b0, P_IDLE});
        end
        @(negedge clk);
        chk("R5 setup pins", {27'b0, pins}, {27'b0, P_SEL});
        chk("R5 write address", {15'b0, mem_addr}, {15'b0, a});
        for (int i = 0; i < WE_CYC; i++) begin
            @(negedge clk);
            chk("R6 pulse pins", {27'b0, pins}, {27'b0, P_PULSE});
            chk("R6 write data", {24'b0, mem_dq_out}, {24'b0, d});
        end
        for (int i = 0; i < REC_CYC; i++) begin
            @(negedge clk);
            chk("R5 recovery pins", {27'b0, pins}, {27'b0, P_SEL});
        end
        @(negedge clk);
        chk("R9 idle pins after write", {27'b0, pins}, {27'b0, P_IDLE});
        chk("R2 ready in idle", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pins in reset", {27'b0, pins}, {27'b0, P_IDLE});
        chk("R1 rd_valid in reset", {31'b0, rd_valid}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pins after reset", {27'b0, pins}, {27'b0, P_IDLE});
        chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_patterns();
        do_write(17'h00000, 8'h3C, 0);
        do_write(17'h1FFFF, 8'hC3, 0);
        do_write(17'h0A5A5, 8'hFF, 0);
        do_write(17'h15A5A, 8'h00, 0);
        do_read(17'h00000, 8'h3C); rd_tail();
        do_read(17'h1FFFF, 8'hC3); rd_tail();
        do_read(17'h0A5A5, 8'hFF); rd_tail();
        do_read(17'h15A5A, 8'h00); rd_tail();
        do_write(17'h00000, 8'hA5, 0);
        do_read(17'h00000, 8'hA5); rd_tail();
    endtask

    task automatic t_turnaround();
        do_read(17'h1FFFF, 8'hC3);
        do_write(17'h00100, 8'h81, turn_extra(1));   // R7: write right after a read
        chk("R10 rd_data held over write", {24'b0, rd_data}, 32'hC3);
        do_read(17'h00100, 8'h81); rd_tail();
        do_write(17'h00101, 8'h7E, turn_extra(2));   // R7: one idle cycle later
        do_read(17'h00101, 8'h7E); rd_tail();
    endtask

    task automatic t_sleep_idle();
        @(posedge clk); #1;
        sleep = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h1FFFF; req_wdata = 8'h11;
        @(negedge clk);
        chk("R8 ready low at once", {31'b0, req_ready}, 32'd0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R8 standby pins", {27'b0, pins}, {27'b0, P_SLEEP});
            chk("R8 no accept in standby", {31'b0, req_ready}, 32'd0);
        end
        @(posedge clk); #1;
        req_valid = 1'b0; sleep = 1'b0;
        do_read(17'h1FFFF, 8'hC3); rd_tail();   // R8: data kept, write blocked
    endtask

    task automatic t_sleep_mid();
        int we_lo = 0, sel = 0;
        issue(1'b1, 17'h02000, 8'h96);
        sleep = 1'b1;
        for (int i = 0; i < 1 + WE_CYC + REC_CYC + 3; i++) begin
            @(negedge clk);
            if (!mem_we_n) we_lo++;
            if (!mem_cs_n) sel++;
        end
        chk("R8 write completes: pulse cycles", we_lo, WE_CYC);
        chk("R8 write completes: selected cycles", sel, 1 + WE_CYC + REC_CYC);
        chk("R8 standby after transfer", {27'b0, pins}, {27'b0, P_SLEEP});
        @(posedge clk); #1 sleep = 1'b0;
        do_read(17'h02000, 8'h96); rd_tail();
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_turnaround();
        t_sleep_idle();
        t_sleep_mid();
        chk("R11 bus conflicts", n_conflict, 0);
        chk("R7 turnaround gap violations", n_turn_bad, 0);
        chk("R7 write edges observed", {31'b0, n_turn_seen > 0}, 32'd1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule